// File: doc/BRIEF.md
# Strobed Serial Register-Access Slave

This block is the device end of a four-signal serial link (serial clock, active-low strobe, data in, data out) that lets a host read and write a small bank of 32-bit control registers. All four link signals are oversampled by a fast system clock. Serial clock, strobe and data in each pass through a two-flop synchroniser, and edges are detected in the system clock domain.

There is no chip-select framing. Every rising serial clock edge with the strobe high shifts one bit into a 40-bit history. A rising edge with the strobe low is the command cycle. Its data bit selects write (1) or read (0). The 8 most recent history bits form the address, and the 32 bits before them form the write data.

A read loads the addressed value into a 32-bit output shifter. The first bit appears on the data-out line at once, and each later bit follows a falling serial clock edge. The register contents drive parallel outputs, the DIP-switch value arrives on a parallel input, and writing 1 to the reset register produces a fixed-length reset-request pulse.

Top module: `sreg_link_slave`

## Requirements
- R1: After the synchronous reset, every writable register reads 0. The parallel register outputs are 0, `sdo_o` is 1 and `rst_req_o` is 0.
- R2: A write frame updates the register named by the address. The frame is 32 data bits, then 8 address bits, each field MSB first, then one strobe-low clock pulse whose data bit is 1. The new value then appears on the matching parallel output.
- R3: A read frame is 8 address bits MSB first, then one strobe-low clock pulse whose data bit is 0. The 32 clock pulses that follow each return one data bit, MSB first. Each bit is valid on `sdo_o` while the serial clock is high, and `sdo_o` changes only after a read command or a falling serial clock edge.
- R4: `sdo_o` is 1 when no read is in progress, including after the 32nd returned bit.
- R5: Address map: 0x00 mode (RW), 0x01 multiplexer (RW), 0x02 display setting (RW), 0x08 DIP-switch input `dip_i` (RO), 0x80 reset control (RW), 0xFF version constant `VERSION` (RO).
- R6: A write to a read-only or unmapped address leaves every register and parallel output unchanged.
- R7: A read of an unmapped address returns 0xFFFFFFFF.
- R8: A write with bit 0 set to the reset register drives `rst_req_o` high for exactly `RST_LEN` system clocks. That bit then clears itself and reads back as 0. A write with bit 0 clear produces no pulse.
- R9: Only the 40 bits shifted in just before the command cycle count. Any earlier bits are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from host |
| strobe_n_i | input | 1 | Active-low command strobe |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial read data, idles high |
| dip_i | input | 32 | DIP-switch value, read at 0x08 |
| mode_o | output | 32 | Mode register |
| mux_o | output | 32 | Multiplexer register |
| disp_o | output | 32 | Display-setting register |
| rst_req_o | output | 1 | Reset-request pulse |

## Verification
The assertions assume the link signals change slowly compared with the system clock. Each serial clock level must last at least four system clocks, so the synchroniser sees every edge and the strobe and data are settled when the rising edge is detected. The stimulus holds each serial clock phase for four system clocks. It changes data and strobe only while the serial clock is low, and it releases the strobe together with the falling edge of the command pulse.

// File: rtl/sreg_link_pkg.sv
package sreg_link_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int HIST_W = DATA_W + ADDR_W;

    localparam logic [ADDR_W-1:0] A_MODE    = 8'h00;
    localparam logic [ADDR_W-1:0] A_MUX     = 8'h01;
    localparam logic [ADDR_W-1:0] A_DISP    = 8'h02;
    localparam logic [ADDR_W-1:0] A_DIP     = 8'h08;
    localparam logic [ADDR_W-1:0] A_RSTCTL  = 8'h80;
    localparam logic [ADDR_W-1:0] A_VERSION = 8'hFF;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    function automatic logic is_writable(input logic [ADDR_W-1:0] a);
        return (a == A_MODE) || (a == A_MUX) || (a == A_DISP) || (a == A_RSTCTL);
    endfunction
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/sreg_frame.sv
module sreg_frame
    import sreg_link_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sclk_s,
    input  logic strobe_n_s,
    input  logic sdi_s,
    output cmd_t cmd,
    output logic sclk_fall
);
    logic              sclk_prev;
    logic [HIST_W-1:0] hist;
    logic              sclk_rise;

    assign sclk_rise = sclk_s & ~sclk_prev;
    assign sclk_fall = ~sclk_s & sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev <= 1'b0;
            hist      <= '0;
            cmd       <= '0;
        end else begin
            sclk_prev <= sclk_s;
            cmd.wr    <= 1'b0;
            cmd.rd    <= 1'b0;
            if (sclk_rise) begin
                if (!strobe_n_s) begin
                    cmd.wr   <= sdi_s;
                    cmd.rd   <= ~sdi_s;
                    cmd.addr <= hist[ADDR_W-1:0];
                    cmd.data <= hist[HIST_W-1:ADDR_W];
                end else begin
                    hist <= {hist[HIST_W-2:0], sdi_s};
                end
            end
        end
    end
endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
    import sreg_link_pkg::*;
#(
    parameter int          RST_LEN = 16,
    parameter logic [31:0] VERSION = 32'h0001_0203
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    input  logic [DATA_W-1:0] dip,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] mode,
    output logic [DATA_W-1:0] mux,
    output logic [DATA_W-1:0] disp,
    output logic              rst_req
);
    localparam int CW = $clog2(RST_LEN + 1);

    logic [DATA_W-1:0] rstctl;
    logic [CW-1:0]     pulse_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode       <= '0;
            mux        <= '0;
            disp       <= '0;
            rstctl     <= '0;
            pulse_left <= '0;
        end else begin
            if (pulse_left != '0) begin
                pulse_left <= pulse_left - 1'b1;
            end else if (rstctl[0]) begin
                pulse_left <= CW'(RST_LEN);
                rstctl[0]  <= 1'b0;
            end
            if (cmd.wr && is_writable(cmd.addr)) begin
                unique case (cmd.addr)
                    A_MODE:   mode   <= cmd.data;
                    A_MUX:    mux    <= cmd.data;
                    A_DISP:   disp   <= cmd.data;
                    default:  rstctl <= cmd.data;
                endcase
            end
        end
    end

    assign rst_req = (pulse_left != '0);

    always_comb begin
        case (cmd.addr)
            A_MODE:    rd_data = mode;
            A_MUX:     rd_data = mux;
            A_DISP:    rd_data = disp;
            A_DIP:     rd_data = dip;
            A_RSTCTL:  rd_data = rstctl;
            A_VERSION: rd_data = VERSION;
            default:   rd_data = '1;
        endcase
    end
endmodule

// File: rtl/sreg_rdout.sv
module sreg_rdout #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] ld_data,
    input  logic          sclk_fall,
    output logic          sdo
);
    localparam int CW = $clog2(DW + 1);

    logic [DW-1:0] sh;
    logic [CW-1:0] left;
    logic          armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh    <= '1;
            left  <= '0;
            armed <= 1'b0;
        end else if (load) begin
            sh    <= ld_data;
            left  <= CW'(DW);
            armed <= 1'b0;
        end else if (sclk_fall && left != '0) begin
            if (!armed) begin
                armed <= 1'b1;
            end else begin
                sh   <= {sh[DW-2:0], 1'b1};
                left <= left - 1'b1;
            end
        end
    end

    assign sdo = (left != '0) ? sh[DW-1] : 1'b1;
endmodule

// File: rtl/sreg_link_slave.sv
module sreg_link_slave
    import sreg_link_pkg::*;
#(
    parameter int          RST_LEN = 16,
    parameter logic [31:0] VERSION = 32'h0001_0203
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sclk_i,
    input  logic        strobe_n_i,
    input  logic        sdi_i,
    output logic        sdo_o,
    input  logic [31:0] dip_i,
    output logic [31:0] mode_o,
    output logic [31:0] mux_o,
    output logic [31:0] disp_o,
    output logic        rst_req_o
);
    logic [2:0]        sync_q;
    cmd_t              cmd;
    logic              sclk_fall;
    logic [DATA_W-1:0] rd_data;

    sreg_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sclk_i, strobe_n_i, sdi_i}),
        .q   (sync_q)
    );

    sreg_frame u_frame (
        .clk        (clk),
        .rst        (rst),
        .sclk_s     (sync_q[2]),
        .strobe_n_s (sync_q[1]),
        .sdi_s      (sync_q[0]),
        .cmd        (cmd),
        .sclk_fall  (sclk_fall)
    );

    sreg_bank #(.RST_LEN(RST_LEN), .VERSION(VERSION)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .dip     (dip_i),
        .rd_data (rd_data),
        .mode    (mode_o),
        .mux     (mux_o),
        .disp    (disp_o),
        .rst_req (rst_req_o)
    );

    sreg_rdout #(.DW(DATA_W)) u_rdout (
        .clk       (clk),
        .rst       (rst),
        .load      (cmd.rd),
        .ld_data   (rd_data),
        .sclk_fall (sclk_fall),
        .sdo       (sdo_o)
    );
endmodule

// File: rtl/sreg_link_chk.sv
module sreg_link_chk
    import sreg_link_pkg::*;
#(
    parameter int RST_LEN = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        sdo_o,
    input logic        rst_req_o,
    input logic [31:0] mode_o,
    input logic [31:0] mux_o,
    input logic [31:0] disp_o,
    input cmd_t        cmd,
    input logic        sclk_fall
);
    int unsigned hi_len;

    always_ff @(posedge clk) begin
        if (rst)            hi_len <= 0;
        else if (rst_req_o) hi_len <= hi_len + 1;
        else                hi_len <= 0;
    end

    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && cmd.addr == A_MODE) |=> (mode_o == $past(cmd.data)));

    a_r3_sdo_moves_on_edge: assert property (@(posedge clk) disable iff (rst)
        !(cmd.rd || sclk_fall) |=> $stable(sdo_o));

    a_r6_ro_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (cmd.wr && !is_writable(cmd.addr)) |=>
            ($stable(mode_o) && $stable(mux_o) && $stable(disp_o)));

    a_r8_pulse_len: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_req_o) |-> (hi_len == RST_LEN));
endmodule

bind sreg_link_slave sreg_link_chk #(.RST_LEN(RST_LEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sdo_o     (sdo_o),
    .rst_req_o (rst_req_o),
    .mode_o    (mode_o),
    .mux_o     (mux_o),
    .disp_o    (disp_o),
    .cmd       (cmd),
    .sclk_fall (sclk_fall)
);

// File: tb/sim_sreg_link_slave.sv
module sim_sreg_link_slave;
    localparam int          RST_LEN = 16;
    localparam logic [31:0] VERSION = 32'h0001_0203;
    localparam logic [31:0] DIP     = 32'hC0DE_1234;

    typedef struct packed {
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [31:0] expect_rd;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
        '{8'h01, 32'h1234_5678, 32'h1234_5678},
        '{8'h02, 32'hFFFF_0001, 32'hFFFF_0001},
        '{8'h80, 32'h0000_0100, 32'h0000_0100},
        '{8'h08, 32'h0000_DEAD, DIP},
        '{8'hFF, 32'h5555_AAAA, VERSION},
        '{8'h05, 32'h0000_0000, 32'hFFFF_FFFF}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, strobe_n = 1'b1, sdi = 1'b0;
    logic sdo, rst_req;
    logic [31:0] mode, mux, disp;
    int checks = 0, fails = 0, pulses = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sreg_link_slave #(.RST_LEN(RST_LEN), .VERSION(VERSION)) u0 (
        .clk(clk), .rst(rst), .sclk_i(sclk), .strobe_n_i(strobe_n), .sdi_i(sdi),
        .sdo_o(sdo), .dip_i(DIP), .mode_o(mode), .mux_o(mux), .disp_o(disp),
        .rst_req_o(rst_req)
    );

    always @(posedge clk) if (!rst && rst_req) pulses++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse(input logic d, input logic strobe, output logic smp);
        sdi = d;
        strobe_n = ~strobe;
        half();
        sclk = 1'b1;
        half();
        smp = sdo;
        sclk = 1'b0;
        strobe_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic s;
        for (int i = 31; i >= 0; i--) pulse(d[i], 1'b0, s);
        for (int i = 7; i >= 0; i--) pulse(a[i], 1'b0, s);
        pulse(1'b1, 1'b1, s);
        half();
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) pulse(a[i], 1'b0, s);
        pulse(1'b0, 1'b1, s);
        for (int i = 31; i >= 0; i--) begin
            pulse(1'b0, 1'b0, s);
            d[i] = s;
        end
        half();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R1 reset state
        check("R1 sdo", {31'd0, sdo}, 32'd1);
        check("R1 rst_req", {31'd0, rst_req}, 32'd0);
        check("R1 mode", mode, 32'd0);
        check("R1 mux", mux, 32'd0);
        check("R1 disp", disp, 32'd0);
        rd(8'h80, r);
        check("R1 rstctl read", r, 32'd0);

        // table walk: R2 R3 R5 R6 R7
        for (int k = 0; k < NV; k++) begin
            wr(VECS[k].addr, VECS[k].wdata);
            rd(VECS[k].addr, r);
            check("R3/R5 readback", r, VECS[k].expect_rd);
            check("R4 sdo idle after read", {31'd0, sdo}, 32'd1);
        end
        check("R2 mode out", mode, VECS[0].wdata);
        check("R2 mux out", mux, VECS[1].wdata);
        check("R6 disp kept after RO writes", disp, VECS[2].wdata);
        check("R8 no pulse for bit0 clear", pulses, 0);

        // R7 a second unmapped address
        rd(8'h40, r);
        check("R7 unmapped read", r, 32'hFFFF_FFFF);

        // R9 leading junk bits discarded
        begin
            logic s;
            for (int i = 0; i < 8; i++) pulse(1'b1, 1'b0, s);
        end
        wr(8'h02, 32'h0BAD_F00D);
        check("R9 disp after junk prefix", disp, 32'h0BAD_F00D);
        rd(8'h02, r);
        check("R9 readback", r, 32'h0BAD_F00D);

        // R8 reset pulse
        pulses = 0;
        wr(8'h80, 32'h0000_0001);
        repeat (RST_LEN + 10) @(negedge clk);
        check("R8 pulse length", pulses, RST_LEN);
        check("R8 rst_req low after", {31'd0, rst_req}, 32'd0);
        rd(8'h80, r);
        check("R8 bit0 self-clears", r, 32'd0);
        check("R4 sdo idle at end", {31'd0, sdo}, 32'd1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule